// File: doc/BRIEF.md
# Ultra DMA Burst Timing Monitor

A synchronous checker that watches the handshake lines of an Ultra DMA data burst and flags the timing rules that the burst breaks. It observes six lines: the data strobe, the recipient's active-low ready line, the transfer request, the stop request, the active-low acknowledge (grant) line and the drive enable of the ready/strobe return line. It also takes a transfer mode select (0, 1 or 2). It does not drive the bus. Every nanosecond limit is turned into whole clock cycles from the `CLK_NS` parameter. Minimums are rounded up and maximums are rounded down, so no check is looser than its rule.

Every input passes through one register stage. Its edges are found by comparing that stage with a second stage. Each interval is a saturating counter that starts on the registered edge of the signal that opens the interval. A rule that is broken raises its own sticky flag and a one-cycle pulse. A burst is the span in which the grant line is low. The burst-scoped rules and the mode are re-armed when grant is negated.

Top module: `udma_burst_mon`

## Requirements
- R1: While grant is asserted and ready is negated, a strobe edge more than the final-strobe limit after the ready negation is a violation. The limit is 75 ns in mode 0, 60 ns in mode 1 and 50 ns in mode 2, rounded down to cycles.
- R2: While grant is asserted and ready is negated, a stop assertion or a request negation is a pause. A pause that comes less than the pause limit after the ready negation is a violation. The limit is 160 ns in mode 0, 125 ns in mode 1 and 100 ns in mode 2, rounded up to cycles.
- R3: While grant is asserted and ready is asserted, a stop assertion or a request negation is a sender termination. A sender termination less than 50 ns after the last strobe edge is a violation.
- R4: A grant edge less than 20 ns after a strobe edge is a violation (setup). A strobe edge less than 20 ns after a grant edge is a violation (hold).
- R5: While grant is negated, dropping the return-line drive enable less than 20 ns after grant negation is a violation.
- R6: Limits in cycles are ceil(ns/CLK_NS) for minimums and floor(ns/CLK_NS) for maximums. At 20 ns these are: final strobe 3/3/2, pause 8/7/5, sender end 3, grant 1, release 1. The delay between the two input changes, in cycles, is compared with these limits.
- R7: The mode is sampled only while grant is negated. A change made during a burst takes effect after the next grant negation. Codes 0, 1 and 2 select modes 0 to 2, and code 3 acts as mode 2.
- R8: Each flag stays set until `clr_i` is asserted. A violation detected in the clearing cycle still sets its flag.
- R9: The pulse and flag bits are laid out as follows: bit 0 final strobe, bit 1 pause, bit 2 sender end, bit 3 grant setup/hold, bit 4 line release. A pulse is high for one cycle. It appears after the second rising clock edge following the offending input change.
- R10: While grant is negated, strobe edges, stop assertions and request negations raise none of bits 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Data strobe |
| rcv_rdy_n_i | input | 1 | Recipient ready, active low |
| xfer_req_i | input | 1 | Transfer request |
| halt_i | input | 1 | Stop request |
| grant_n_i | input | 1 | Acknowledge, active low |
| rdy_drv_en_i | input | 1 | Drive enable of the ready/strobe return line |
| mode_i | input | 2 | Transfer mode select |
| clr_i | input | 1 | Synchronous clear of the flags |
| viol_flag_o | output | 5 | Sticky violation flags |
| viol_pulse_o | output | 5 | One-cycle violation pulses |

## Verification
The bench places strobe and pause events exactly on each limit and one cycle past it. This exposes an off-by-one counter, or the wrong rounding direction, which would flag a legal edge or pass a late one. The same delay is applied in mode 0 and in mode 2 to prove the limits follow the mode. A mode change inside a burst is also tried: a design that loaded it at once would flag a legal edge. Simultaneous grant and strobe edges, release right at grant negation, and termination events outside a burst are driven too. These catch a missing setup path, a release check that ignores the wait, and a design that checks burst rules while idle.

// File: rtl/udma_mon_pkg.sv
package udma_mon_pkg;
  localparam int unsigned NUM_RULES = 5;
  localparam int unsigned NUM_MODES = 3;

  localparam int unsigned R_FIN   = 0;
  localparam int unsigned R_PAUSE = 1;
  localparam int unsigned R_SEND  = 2;
  localparam int unsigned R_GRANT = 3;
  localparam int unsigned R_REL   = 4;

  localparam int unsigned FIN_NS   [NUM_MODES] = '{75, 60, 50};
  localparam int unsigned PAUSE_NS [NUM_MODES] = '{160, 125, 100};
  localparam int unsigned SEND_NS  = 50;
  localparam int unsigned GRANT_NS = 20;
  localparam int unsigned REL_NS   = 20;

  typedef logic [1:0] mode_t;

  typedef struct packed {
    logic stb;
    logic rdy_n;
    logic req;
    logic halt;
    logic gnt_n;
    logic drv_en;
  } bus_t;

  localparam bus_t BUS_RST = '{stb: 1'b0, rdy_n: 1'b1, req: 1'b0,
                               halt: 1'b0, gnt_n: 1'b1, drv_en: 1'b0};

  function automatic int unsigned ns_ceil(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned ns_floor(int unsigned ns, int unsigned clk_ns);
    return ns / clk_ns;
  endfunction
endpackage

// File: rtl/udma_mon_sync.sv
module udma_mon_sync #(
  parameter int unsigned    W   = 6,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= RST;
      prv_o <= RST;
    end else begin
      cur_o <= d_i;
      prv_o <= cur_o;
    end
  end
endmodule

// File: rtl/udma_mon_interval.sv
module udma_mon_interval #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rearm_i,
  output logic [CW-1:0] elapsed_o
);
  localparam logic [CW-1:0] SAT = '1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= SAT;
    else if (start_i)        cnt_q <= ONE;
    else if (rearm_i)        cnt_q <= SAT;
    else if (cnt_q != SAT)   cnt_q <= cnt_q + ONE;
  end

  // elapsed is zero in the cycle the opening edge is seen
  assign elapsed_o = start_i ? '0 : cnt_q;
endmodule

// File: rtl/udma_mon_limits.sv
module udma_mon_limits
  import udma_mon_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned CW     = 8
) (
  input  mode_t         mode_i,
  output logic [CW-1:0] fin_max_o,
  output logic [CW-1:0] pause_min_o,
  output logic [CW-1:0] send_min_o,
  output logic [CW-1:0] grant_min_o,
  output logic [CW-1:0] rel_min_o
);
  localparam mode_t TOP_MODE = mode_t'(NUM_MODES - 1);

  logic [CW-1:0] fin_tab   [NUM_MODES];
  logic [CW-1:0] pause_tab [NUM_MODES];
  mode_t         idx;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign fin_tab[m]   = CW'(ns_floor(FIN_NS[m], CLK_NS));
    assign pause_tab[m] = CW'(ns_ceil(PAUSE_NS[m], CLK_NS));
  end

  assign idx         = (mode_i > TOP_MODE) ? TOP_MODE : mode_i;
  assign fin_max_o   = fin_tab[idx];
  assign pause_min_o = pause_tab[idx];
  assign send_min_o  = CW'(ns_ceil(SEND_NS, CLK_NS));
  assign grant_min_o = CW'(ns_ceil(GRANT_NS, CLK_NS));
  assign rel_min_o   = CW'(ns_ceil(REL_NS, CLK_NS));
endmodule

// File: rtl/udma_mon_flags.sv
module udma_mon_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] pulse_o
);
  for (genvar r = 0; r < N; r++) begin : g_rule
    logic flag_q, pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q  <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        flag_q  <= (flag_q & ~clr_i) | hit_i[r];
        pulse_q <= hit_i[r];
      end
    end
    assign flag_o[r]  = flag_q;
    assign pulse_o[r] = pulse_q;
  end
endmodule

// File: rtl/udma_burst_mon.sv
module udma_burst_mon
  import udma_mon_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned CW     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stb_i,
  input  logic                 rcv_rdy_n_i,
  input  logic                 xfer_req_i,
  input  logic                 halt_i,
  input  logic                 grant_n_i,
  input  logic                 rdy_drv_en_i,
  input  logic [1:0]           mode_i,
  input  logic                 clr_i,
  output logic [NUM_RULES-1:0] viol_flag_o,
  output logic [NUM_RULES-1:0] viol_pulse_o
);
  localparam int unsigned BW = $bits(bus_t);

  bus_t raw, cur, prv;
  assign raw = '{stb: stb_i, rdy_n: rcv_rdy_n_i, req: xfer_req_i,
                 halt: halt_i, gnt_n: grant_n_i, drv_en: rdy_drv_en_i};

  udma_mon_sync #(.W(BW), .RST(BUS_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .cur_o(cur), .prv_o(prv)
  );

  logic stb_tgl, rdy_neg, gnt_tgl, gnt_rise, drv_fall, term_evt, in_burst;
  assign stb_tgl  = cur.stb ^ prv.stb;
  assign rdy_neg  = cur.rdy_n & ~prv.rdy_n;
  assign gnt_tgl  = cur.gnt_n ^ prv.gnt_n;
  assign gnt_rise = cur.gnt_n & ~prv.gnt_n;
  assign drv_fall = ~cur.drv_en & prv.drv_en;
  assign term_evt = (cur.halt & ~prv.halt) | (~cur.req & prv.req);
  assign in_burst = ~cur.gnt_n;

  // mode frozen for the whole burst
  mode_t act_mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_mode_q <= '0;
    else if (cur.gnt_n) act_mode_q <= mode_i;
  end

  logic [CW-1:0] fin_max, pause_min, send_min, grant_min, rel_min;
  udma_mon_limits #(.CLK_NS(CLK_NS), .CW(CW)) u_lim (
    .mode_i(act_mode_q), .fin_max_o(fin_max), .pause_min_o(pause_min),
    .send_min_o(send_min), .grant_min_o(grant_min), .rel_min_o(rel_min)
  );

  logic [CW-1:0] el_stb, el_rdy, el_gnt;

  udma_mon_interval #(.CW(CW)) u_int_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(stb_tgl), .rearm_i(gnt_rise), .elapsed_o(el_stb)
  );
  udma_mon_interval #(.CW(CW)) u_int_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rdy_neg), .rearm_i(gnt_rise), .elapsed_o(el_rdy)
  );
  udma_mon_interval #(.CW(CW)) u_int_gnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(gnt_tgl), .rearm_i(1'b0), .elapsed_o(el_gnt)
  );

  logic [NUM_RULES-1:0] hit;
  assign hit[R_FIN]   = in_burst & cur.rdy_n & stb_tgl & (el_rdy > fin_max);
  assign hit[R_PAUSE] = in_burst & cur.rdy_n & term_evt & (el_rdy < pause_min);
  assign hit[R_SEND]  = in_burst & ~cur.rdy_n & term_evt & (el_stb < send_min);
  assign hit[R_GRANT] = (gnt_tgl & (el_stb < grant_min)) | (stb_tgl & (el_gnt < grant_min));
  assign hit[R_REL]   = cur.gnt_n & drv_fall & (el_gnt < rel_min);

  udma_mon_flags #(.N(NUM_RULES)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .hit_i(hit),
    .flag_o(viol_flag_o), .pulse_o(viol_pulse_o)
  );
endmodule

// File: rtl/udma_burst_mon_chk.sv
module udma_burst_mon_chk #(
  parameter int unsigned N = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         in_burst,
  input logic [1:0]   act_mode,
  input logic [N-1:0] viol_flag_o,
  input logic [N-1:0] viol_pulse_o
);
  AST_PULSE_IN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_pulse_o & ~viol_flag_o) == '0); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((viol_flag_o & $past(viol_flag_o)) == $past(viol_flag_o))); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (viol_flag_o == viol_pulse_o)); // R8

  AST_IDLE_NO_BURST_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_burst |=> (viol_pulse_o[2:0] == 3'b000)); // R10

  AST_RELEASE_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst |=> !viol_pulse_o[4]); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_burst && $past(in_burst)) |-> $stable(act_mode)); // R7
endmodule

bind udma_burst_mon udma_burst_mon_chk #(.N(udma_mon_pkg::NUM_RULES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .in_burst(in_burst),
  .act_mode(act_mode_q), .viol_flag_o(viol_flag_o), .viol_pulse_o(viol_pulse_o)
);

// File: tb/udma_burst_mon_tb.sv
module udma_burst_mon_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, rdy_n = 1'b1, req = 1'b0, halt = 1'b0, gnt_n = 1'b1;
  logic drv_en = 1'b1, clr = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [4:0] flag, pulse;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udma_burst_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .rcv_rdy_n_i(rdy_n), .xfer_req_i(req),
    .halt_i(halt), .grant_n_i(gnt_n), .rdy_drv_en_i(drv_en), .mode_i(mode),
    .clr_i(clr), .viol_flag_o(flag), .viol_pulse_o(pulse)
  );

  typedef struct { int due; bit is_flag; logic [4:0] exp; string tag; } item_t;
  item_t sb[$];

  // monitor: pops expected items when due
  initial forever begin
    @(negedge clk); #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [4:0] act;
      it = sb.pop_front();
      act = it.is_flag ? flag : pulse;
      n_chk++;
      if (act !== it.exp || it.due != cyc) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_pulse(logic [4:0] e, string tag);
    sb.push_back('{cyc + 2, 1'b0, e, tag});
  endtask

  task automatic exp_flag(logic [4:0] e, string tag);
    sb.push_back('{cyc + 1, 1'b1, e, tag});
  endtask

  task automatic start_burst(logic [1:0] m);
    mode = m; req = 1'b1; halt = 1'b0; rdy_n = 1'b0;
    tick(2);
    gnt_n = 1'b0;
    tick(4);
  endtask

  task automatic end_burst();
    rdy_n = 1'b0; halt = 1'b0; req = 1'b1;
    tick(2);
    gnt_n = 1'b1;
    tick(3);
    clr = 1'b1;
    exp_flag(5'b0, "R8 flags cleared");
    tick(1);
    clr = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    exp_flag(5'b0, "R8 reset flags");
    exp_pulse(5'b0, "R9 reset pulses");
    tick(3);

    // R1 mode 0, limit 3 cycles
    start_burst(2'd0);
    rdy_n = 1'b1; exp_pulse(5'b0, "R1 negation alone");
    tick(3); stb = ~stb; exp_pulse(5'b0, "R1 R6 edge at limit mode0");
    tick(1); stb = ~stb; exp_pulse(5'b00001, "R1 late edge mode0");
    tick(1); exp_pulse(5'b0, "R9 single cycle pulse");
    tick(2); exp_flag(5'b00001, "R8 flag sticky");
    tick(2);
    end_burst();

    // R1 mode 2, limit 2 cycles
    start_burst(2'd2);
    rdy_n = 1'b1;
    tick(3); stb = ~stb; exp_pulse(5'b00001, "R1 late edge mode2");
    tick(3);
    end_burst();

    // R2 mode 0, min 8 cycles
    start_burst(2'd0);
    rdy_n = 1'b1;
    tick(5); halt = 1'b1; exp_pulse(5'b00010, "R2 early pause mode0");
    tick(3);
    end_burst();
    start_burst(2'd0);
    rdy_n = 1'b1;
    tick(8); halt = 1'b1; exp_pulse(5'b0, "R2 R6 pause at limit mode0");
    tick(3);
    end_burst();

    // R2 mode 2, min 5 cycles
    start_burst(2'd2);
    rdy_n = 1'b1;
    tick(4); req = 1'b0; exp_pulse(5'b00010, "R2 early pause mode2");
    tick(3);
    end_burst();

    // R3 sender end, min 3 cycles
    start_burst(2'd0);
    stb = ~stb;
    tick(2); halt = 1'b1; exp_pulse(5'b00100, "R3 early sender stop");
    tick(3);
    end_burst();
    start_burst(2'd0);
    stb = ~stb;
    tick(3); req = 1'b0; exp_pulse(5'b0, "R3 R6 sender end at limit");
    tick(3);
    end_burst();

    // R4 grant setup/hold
    mode = 2'd0; req = 1'b1; rdy_n = 1'b0;
    tick(2);
    gnt_n = 1'b0; stb = ~stb; exp_pulse(5'b01000, "R4 strobe with grant");
    tick(3);
    end_burst();
    gnt_n = 1'b0;
    tick(1); stb = ~stb; exp_pulse(5'b0, "R4 hold met");
    tick(3);
    stb = ~stb; gnt_n = 1'b1; exp_pulse(5'b01000, "R4 setup at negation");
    tick(3);
    clr = 1'b1; tick(1); clr = 1'b0; tick(2);

    // R5 line release
    start_burst(2'd0);
    gnt_n = 1'b1; drv_en = 1'b0; exp_pulse(5'b10000, "R5 release at negation");
    tick(3);
    drv_en = 1'b1; clr = 1'b1; tick(1); clr = 1'b0; tick(2);
    gnt_n = 1'b0;
    tick(4);
    gnt_n = 1'b1;
    tick(1); drv_en = 1'b0; exp_pulse(5'b0, "R5 release after wait");
    tick(3);
    drv_en = 1'b1;
    tick(2);

    // R7 mode change mid-burst
    start_burst(2'd0);
    mode = 2'd2;
    tick(2);
    rdy_n = 1'b1;
    tick(3); stb = ~stb; exp_pulse(5'b0, "R7 mode held in burst");
    tick(3);
    end_burst();
    gnt_n = 1'b0;
    tick(4);
    rdy_n = 1'b1;
    tick(3); stb = ~stb; exp_pulse(5'b00001, "R7 mode after negation");
    tick(3);
    end_burst();
    start_burst(2'd3);
    rdy_n = 1'b1;
    tick(3); stb = ~stb; exp_pulse(5'b00001, "R7 code 3 as mode2");
    tick(3);
    end_burst();

    // R10 idle events
    stb = ~stb;
    tick(1); req = 1'b0; exp_pulse(5'b0, "R10 idle termination");
    tick(2); rdy_n = 1'b1;
    tick(5); stb = ~stb; exp_pulse(5'b0, "R10 idle late strobe");
    tick(1); halt = 1'b1; exp_pulse(5'b0, "R10 idle stop");
    tick(3);
    exp_flag(5'b0, "R10 idle flags");
    tick(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule